// File: doc/BRIEF.md
# Hot-Plug Slot Command Processor

This block interprets hot-plug controller commands for a set of card slots. Software writes a command code byte together with a target byte; the block then updates a status word per slot, the secondary bus speed field and a small command status word. At the end of each command it pulses a completion strobe. Two group commands, one that powers every slot and one that enables every slot, visit the slots one per clock while the busy bit is high.

Each slot also has pulse inputs for card insertion and card removal. A removal empties a slot only when the slot is disabled with its power indicator off. Slot events (presence change, attention button, retention latch change) are latched per slot until they are cleared through a per-slot clear input. Power sequencing and interrupt generation lie outside this block.

Top module: `hpc_cmd_proc`

## Requirements
- R1: After reset, a slot whose `card_present` bit is 1 reads state 2 (enabled), power indicator 1 (on), latch closed and presence 0. A slot without a card reads state 3 (disabled), power indicator 3 (off), latch open and presence 3 (empty). In both cases attention is 0, events are 0, `cmd_status` is 0, `bus_speed` is 0 and `cmd_done` is 0. The slot word layout is: bits 1:0 state, bits 3:2 power indicator, bits 5:4 attention indicator, bit 6 latch open, bits 8:7 presence, bit 9 speed flag (always 0).
- R2: Codes 0x00..0x3F are slot commands. Code bits 1:0 hold the requested state, bits 3:2 the power indicator and bits 5:4 the attention indicator. The slot selected is target[4:0] minus 1. An indicator field that is nonzero replaces the stored indicator, and a zero field leaves it unchanged.
- R3: A slot changes state only from disabled (3) to power-only (1) or enabled (2), or from enabled or power-only to disabled. Every other request leaves the state unchanged.
- R4: A slot command is invalid when target[4:0] is 0, when it selects an index at or above the slot count, or when it asks for power-only on an enabled slot. An invalid command sets `cmd_status` bit 2 and changes no slot.
- R5: When a slot enters disabled and its power indicator (after this command's update) is off, the slot gets latch open and presence 3, and all three event bits are set (bit 0 presence, bit 1 button, bit 2 latch).
- R6: Codes 0x40..0x47 carry a bus speed in code bits 2:0. Speed 0 is stored. Any other speed sets `cmd_status` bit 3 and leaves `bus_speed` unchanged.
- R7: Codes 0x48 (power all) and 0x49 (enable all) fail with `cmd_status` bit 2 and change no slot if any slot is enabled.
- R8: Otherwise a group command visits slots 0..N-1, one per clock. A slot with its latch closed gets request power-only (0x48) or enabled (0x49), with the power indicator on. A slot with its latch open gets the power indicator off and no state request. `cmd_status` bit 0 stays 1 for exactly N cycles.
- R9: A command write that arrives while bit 0 of `cmd_status` is set is ignored.
- R10: Each accepted command first clears `cmd_status` bits 3:1. Codes 0x4A..0xFF are invalid and set bit 2. `cmd_done` is high for one cycle after every command ends, including invalid ones.
- R11: On `card_insert`, a slot with its latch open gets latch closed, presence 0 and all three events. A slot with its latch already closed gets only the button event. On `card_remove`, the button event is set. If the slot is also disabled with the power indicator off, it gets latch open, presence 3 and the latch and presence events.
- R12: `evt_clear[i]` clears the latched events of slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | NUM_SLOTS | Slot occupancy sampled during reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 8 | Target slot byte (bits 4:0 used) |
| card_insert | input | NUM_SLOTS | Card insertion pulse per slot |
| card_remove | input | NUM_SLOTS | Removal request pulse per slot |
| evt_clear | input | NUM_SLOTS | Clear latched events per slot |
| slot_status | output | NUM_SLOTS*10 | Slot words, slot i at bits i*10 and up |
| slot_events | output | NUM_SLOTS*3 | Latched events, slot i at bits i*3 and up |
| bus_speed | output | 3 | Secondary bus speed |
| cmd_status | output | 4 | Bit 0 busy, bit 2 invalid command, bit 3 invalid mode |
| cmd_done | output | 1 | One-cycle command completion pulse |

## Verification
The hardest situation to reach is a group command that actually runs. Every slot must first be out of the enabled state, and the slots must have a mix of open and closed latches. The stimulus builds this in steps: it disables both occupied slots with single-slot commands, using one power-off request so that one slot is freed. It then inserts a card into an empty slot and requests removal on another. Only after that does it issue power-all and enable-all. During the walk it also issues a destructive write to confirm that the write is dropped.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic [1:0] {
    ST_KEEP = 2'd0,
    ST_PWR  = 2'd1,
    ST_EN   = 2'd2,
    ST_DIS  = 2'd3
  } slot_st_e;

  localparam logic [1:0] IND_KEEP   = 2'd0;
  localparam logic [1:0] IND_ON     = 2'd1;
  localparam logic [1:0] IND_OFF    = 2'd3;
  localparam logic [1:0] PRES_CARD  = 2'd0;
  localparam logic [1:0] PRES_EMPTY = 2'd3;

  localparam int EV_PRES  = 0;
  localparam int EV_BTN   = 1;
  localparam int EV_LATCH = 2;
  localparam int EV_W     = 3;

  typedef struct packed {
    logic       spd66;
    logic [1:0] pres;
    logic       latch_open;
    logic [1:0] attn;
    logic [1:0] pwr;
    slot_st_e   st;
  } slot_word_t;

  localparam int WORD_W = $bits(slot_word_t);

  typedef enum logic [2:0] {
    OP_SLOT,
    OP_SPEED,
    OP_GRP_PWR,
    OP_GRP_EN,
    OP_BAD
  } op_e;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op,
  output logic [1:0] req_st,
  output logic [1:0] req_pwr,
  output logic [1:0] req_attn,
  output logic [2:0] speed
);

  always_comb begin
    req_st   = code[1:0];
    req_pwr  = code[3:2];
    req_attn = code[5:4];
    speed    = code[2:0];
    if (code[7:6] == 2'b00)       op = OP_SLOT;
    else if (code[7:3] == 5'b01000) op = OP_SPEED;
    else if (code == 8'h48)       op = OP_GRP_PWR;
    else if (code == 8'h49)       op = OP_GRP_EN;
    else                          op = OP_BAD;
  end

endmodule

// File: rtl/hpc_group_seq.sv
module hpc_group_seq #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  assign last = busy && (idx == IDX_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && idx == IDX_W'($past(idx) + 1'b1))); // R8
  AST_WALK_END: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy); // R8

endmodule

// File: rtl/hpc_slot.sv
module hpc_slot
  import hpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             card_at_reset,
  input  logic             cmd_en,
  input  logic [1:0]       req_st,
  input  logic [1:0]       req_pwr,
  input  logic [1:0]       req_attn,
  input  logic             card_insert,
  input  logic             card_remove,
  input  logic             evt_clear,
  output slot_word_t       word,
  output logic [EV_W-1:0]  events
);

  slot_word_t      nxt;
  logic [EV_W-1:0] ev_n;

  always_comb begin
    nxt  = word;
    ev_n = events & {EV_W{~evt_clear}};
    if (cmd_en) begin
      if (req_pwr  != IND_KEEP) nxt.pwr  = req_pwr;
      if (req_attn != IND_KEEP) nxt.attn = req_attn;
      if (word.st == ST_DIS && (req_st == ST_PWR || req_st == ST_EN)) begin
        nxt.st = slot_st_e'(req_st);
      end else if ((word.st == ST_EN || word.st == ST_PWR) && req_st == ST_DIS) begin
        nxt.st = ST_DIS;
        if (nxt.pwr == IND_OFF) begin
          nxt.latch_open = 1'b1;
          nxt.pres       = PRES_EMPTY;
          ev_n           = '1;
        end
      end
    end
    if (card_insert) begin
      if (nxt.latch_open) begin
        nxt.latch_open = 1'b0;
        nxt.pres       = PRES_CARD;
        ev_n           = '1;
      end else begin
        ev_n[EV_BTN] = 1'b1;
      end
    end
    if (card_remove) begin
      ev_n[EV_BTN] = 1'b1;
      if (nxt.st == ST_DIS && nxt.pwr == IND_OFF) begin
        nxt.latch_open = 1'b1;
        nxt.pres       = PRES_EMPTY;
        ev_n[EV_LATCH] = 1'b1;
        ev_n[EV_PRES]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      events <= '0;
      if (card_at_reset)
        word <= '{spd66: 1'b0, pres: PRES_CARD, latch_open: 1'b0,
                  attn: IND_KEEP, pwr: IND_ON, st: ST_EN};
      else
        word <= '{spd66: 1'b0, pres: PRES_EMPTY, latch_open: 1'b1,
                  attn: IND_KEEP, pwr: IND_OFF, st: ST_DIS};
    end else begin
      word   <= nxt;
      events <= ev_n;
    end
  end

  AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $rose(word.latch_open) |-> (word.pres == PRES_EMPTY)); // R5
  AST_EN_NOT_PWR: assert property (@(posedge clk) disable iff (rst)
    (word.st == ST_EN) |=> (word.st != ST_PWR)); // R4

endmodule

// File: rtl/hpc_cmd_proc.sv
module hpc_cmd_proc
  import hpc_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SLOTS-1:0]          card_present,
  input  logic                          cmd_wr,
  input  logic [7:0]                    cmd_code,
  input  logic [7:0]                    cmd_target,
  input  logic [NUM_SLOTS-1:0]          card_insert,
  input  logic [NUM_SLOTS-1:0]          card_remove,
  input  logic [NUM_SLOTS-1:0]          evt_clear,
  output logic [NUM_SLOTS*WORD_W-1:0]   slot_status,
  output logic [NUM_SLOTS*EV_W-1:0]     slot_events,
  output logic [2:0]                    bus_speed,
  output logic [3:0]                    cmd_status,
  output logic                          cmd_done
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  op_e        op;
  logic [1:0] req_st, req_pwr, req_attn;
  logic [2:0] speed;

  hpc_cmd_decode u_dec (
    .code     (cmd_code),
    .op       (op),
    .req_st   (req_st),
    .req_pwr  (req_pwr),
    .req_attn (req_attn),
    .speed    (speed)
  );

  slot_word_t words [NUM_SLOTS];
  logic       busy, last, grp_go, grp_en_q;
  logic [IDX_W-1:0] walk_idx;

  wire        accept   = cmd_wr && !busy;
  wire  [7:0] tgt      = cmd_target & 8'h1F;
  wire  [7:0] slot_sel = tgt - 8'd1;
  wire        tgt_ok   = (tgt != 8'd0) && (int'(tgt) <= NUM_SLOTS);

  slot_st_e tgt_st;
  logic     any_en;
  always_comb begin
    tgt_st = ST_KEEP;
    any_en = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_sel == 8'(i)) tgt_st = words[i].st;
      if (words[i].st == ST_EN) any_en = 1'b1;
    end
  end

  wire slot_ok = tgt_ok && !(tgt_st == ST_EN && req_st == ST_PWR);
  wire slot_go = accept && op == OP_SLOT && slot_ok;
  assign grp_go = accept && (op == OP_GRP_PWR || op == OP_GRP_EN) && !any_en;

  hpc_group_seq #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (grp_go),
    .busy  (busy),
    .idx   (walk_idx),
    .last  (last)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic       walk_hit, en;
    logic [1:0] s_st, s_pwr, s_attn;
    logic [EV_W-1:0] ev;
    always_comb begin
      walk_hit = busy && (walk_idx == IDX_W'(i));
      en       = walk_hit || (slot_go && slot_sel == 8'(i));
      if (walk_hit) begin
        s_st   = words[i].latch_open ? ST_KEEP : (grp_en_q ? ST_EN : ST_PWR);
        s_pwr  = words[i].latch_open ? IND_OFF : IND_ON;
        s_attn = IND_KEEP;
      end else begin
        s_st   = req_st;
        s_pwr  = req_pwr;
        s_attn = req_attn;
      end
    end

    hpc_slot u_slot (
      .clk           (clk),
      .rst           (rst),
      .card_at_reset (card_present[i]),
      .cmd_en        (en),
      .req_st        (s_st),
      .req_pwr       (s_pwr),
      .req_attn      (s_attn),
      .card_insert   (card_insert[i]),
      .card_remove   (card_remove[i]),
      .evt_clear     (evt_clear[i]),
      .word          (words[i]),
      .events        (ev)
    );

    assign slot_status[i*WORD_W +: WORD_W] = words[i];
    assign slot_events[i*EV_W +: EV_W]     = ev;
  end

  logic       bad_cmd_q, bad_mode_q;
  logic [2:0] bus_speed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_cmd_q   <= 1'b0;
      bad_mode_q  <= 1'b0;
      bus_speed_q <= 3'd0;
      cmd_done    <= 1'b0;
      grp_en_q    <= 1'b0;
    end else begin
      cmd_done <= last;
      if (accept) begin
        bad_cmd_q  <= 1'b0;
        bad_mode_q <= 1'b0;
        case (op)
          OP_SLOT: begin
            if (!slot_ok) bad_cmd_q <= 1'b1;
            cmd_done <= 1'b1;
          end
          OP_SPEED: begin
            if (speed == 3'd0) bus_speed_q <= speed;
            else               bad_mode_q  <= 1'b1;
            cmd_done <= 1'b1;
          end
          OP_GRP_PWR, OP_GRP_EN: begin
            grp_en_q <= (op == OP_GRP_EN);
            if (any_en) begin
              bad_cmd_q <= 1'b1;
              cmd_done  <= 1'b1;
            end
          end
          default: begin
            bad_cmd_q <= 1'b1;
            cmd_done  <= 1'b1;
          end
        endcase
      end
    end
  end

  assign bus_speed  = bus_speed_q;
  assign cmd_status = {bad_mode_q, bad_cmd_q, 1'b0, busy};

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> ($stable(bus_speed_q) && $stable(bad_cmd_q) && $stable(bad_mode_q))); // R9
  AST_INVALID_ENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(bad_cmd_q) |-> cmd_done); // R10

endmodule

// File: tb/hpc_cmd_proc_bench.sv
module hpc_cmd_proc_bench;

  localparam int N  = 4;
  localparam int WW = 10;
  localparam int IW = 4 + 3 + N*WW + N*3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] card_present = 4'b0101;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_code = '0, cmd_target = '0;
  logic [N-1:0] card_insert = '0, card_remove = '0, evt_clear = '0;
  logic [N*WW-1:0] slot_status;
  logic [N*3-1:0]  slot_events;
  logic [2:0] bus_speed;
  logic [3:0] cmd_status;
  logic cmd_done;

  hpc_cmd_proc #(.NUM_SLOTS(N)) u_hpc_cmd_proc (
    .clk(clk), .rst(rst), .card_present(card_present), .cmd_wr(cmd_wr),
    .cmd_code(cmd_code), .cmd_target(cmd_target), .card_insert(card_insert),
    .card_remove(card_remove), .evt_clear(evt_clear), .slot_status(slot_status),
    .slot_events(slot_events), .bus_speed(bus_speed), .cmd_status(cmd_status),
    .cmd_done(cmd_done)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side model of the slots, built from the requirements
  int st[N], pw[N], at[N], lo[N], pr[N], ev[N];
  logic [3:0] m_cs;

  function automatic logic [N*WW-1:0] m_status();
    logic [N*WW-1:0] v;
    for (int i = 0; i < N; i++)
      v[i*WW +: WW] = {1'b0, 2'(pr[i]), 1'(lo[i]), 2'(at[i]), 2'(pw[i]), 2'(st[i])};
    return v;
  endfunction

  function automatic logic [N*3-1:0] m_events();
    logic [N*3-1:0] v;
    for (int i = 0; i < N; i++) v[i*3 +: 3] = 3'(ev[i]);
    return v;
  endfunction

  task automatic m_slot(input int i, input int rs, input int rp, input int ra);
    if (rp != 0) pw[i] = rp;
    if (ra != 0) at[i] = ra;
    if (st[i] == 3 && (rs == 1 || rs == 2)) st[i] = rs;
    else if ((st[i] == 2 || st[i] == 1) && rs == 3) begin
      st[i] = 3;
      if (pw[i] == 3) begin lo[i] = 1; pr[i] = 3; ev[i] = 7; end
    end
  endtask

  logic [IW-1:0] exp_q[$];
  string         tag_q[$];

  task automatic m_cmd(input logic [7:0] code, input logic [7:0] tgt, input string tag);
    int t, anyen;
    m_cs = 4'd0;
    if (code < 8'h40) begin
      t = int'(tgt & 8'h1F);
      if (t == 0 || t > N) m_cs[2] = 1'b1;
      else if (st[t-1] == 2 && code[1:0] == 2'd1) m_cs[2] = 1'b1;
      else m_slot(t-1, int'(code[1:0]), int'(code[3:2]), int'(code[5:4]));
    end else if (code < 8'h48) begin
      if (code[2:0] != 3'd0) m_cs[3] = 1'b1;
    end else if (code == 8'h48 || code == 8'h49) begin
      anyen = 0;
      for (int i = 0; i < N; i++) if (st[i] == 2) anyen = 1;
      if (anyen != 0) m_cs[2] = 1'b1;
      else for (int i = 0; i < N; i++) begin
        if (lo[i] == 0) m_slot(i, (code == 8'h49) ? 2 : 1, 1, 0);
        else            m_slot(i, 0, 3, 0);
      end
    end else m_cs[2] = 1'b1;
    exp_q.push_back({m_cs, 3'b000, m_status(), m_events()});
    tag_q.push_back(tag);
  endtask

  // monitor: one expected item per completion pulse
  always @(negedge clk) begin
    if (!rst && cmd_done) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected cmd_done actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), 64'({cmd_status, bus_speed, slot_status, slot_events}),
              64'(exp_q.pop_front()));
      end
    end
  end

  task automatic send(input logic [7:0] code, input logic [7:0] tgt, input string tag);
    @(negedge clk);
    m_cmd(code, tgt, tag);
    cmd_code = code; cmd_target = tgt; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic group(input logic [7:0] code, input string tag);
    int busy_cycles;
    send(code, 8'd0, tag);
    busy_cycles = 0;
    while (cmd_status[0]) begin
      busy_cycles++;
      cmd_wr = (busy_cycles == 2);   // R9: destructive write during the walk
      cmd_code = 8'h0F; cmd_target = 8'd2;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    check("R8 busy cycles", 64'(busy_cycles), 64'(N));
  endtask

  task automatic card(input bit ins, input int i, input string tag);
    @(negedge clk);
    if (ins) begin
      card_insert[i] = 1'b1;
      if (lo[i] != 0) begin lo[i] = 0; pr[i] = 0; ev[i] = 7; end
      else ev[i] = ev[i] | 2;
    end else begin
      card_remove[i] = 1'b1;
      ev[i] = ev[i] | 2;
      if (st[i] == 3 && pw[i] == 3) begin lo[i] = 1; pr[i] = 3; ev[i] = 7; end
    end
    @(negedge clk);
    card_insert = '0; card_remove = '0;
    check(tag, 64'({slot_status, slot_events}), 64'({m_status(), m_events()}));
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      if (card_present[i]) begin st[i] = 2; pw[i] = 1; lo[i] = 0; pr[i] = 0; end
      else                 begin st[i] = 3; pw[i] = 3; lo[i] = 1; pr[i] = 3; end
      at[i] = 0; ev[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 slot0 word", 64'(slot_status[0 +: WW]), 64'h006);
    check("R1 slot1 word", 64'(slot_status[WW +: WW]), 64'h1CF);
    check("R1 all words", 64'(slot_status), 64'(m_status()));
    check("R1 status/speed/done/events", 64'({cmd_status, bus_speed, cmd_done, slot_events}), 64'd0);

    send(8'h49, 8'd0, "R7 enable-all with enabled slots");
    send(8'h01, 8'd1, "R4 power-only on enabled slot");
    send(8'h0A, 8'd0, "R4 target zero");
    send(8'h0A, 8'd5, "R4 target beyond slot count");
    send(8'h20, 8'h21, "R2 attention blink, upper target bits dropped");
    send(8'h0F, 8'd1, "R5 disable with power off frees slot");
    send(8'h07, 8'd3, "R3 disable with power on keeps card");
    send(8'h06, 8'd3, "R3 disabled to enabled");
    send(8'h03, 8'd3, "R3 enabled to disabled");

    @(negedge clk); evt_clear[0] = 1'b1; ev[0] = 0;
    @(negedge clk); evt_clear = '0;
    check("R12 events cleared", 64'(slot_events), 64'(m_events()));

    send(8'h40, 8'd0, "R6 speed zero accepted");
    send(8'h43, 8'd0, "R6 nonzero speed invalid mode");
    send(8'h00, 8'd2, "R10 status bits cleared by next command");
    send(8'h50, 8'd0, "R10 undefined code 0x50");
    send(8'hFF, 8'd0, "R10 undefined code 0xFF");

    card(1'b1, 1, "R11 insert into open slot");
    card(1'b1, 1, "R11 insert into closed slot");
    card(1'b0, 3, "R11 remove on disabled off slot");

    group(8'h48, "R8 power-all walk, R9 write ignored");
    group(8'h49, "R8 enable-all walk on power-only slots");
    send(8'h03, 8'd2, "R3 power-only to disabled");
    group(8'h49, "R8 enable-all walk");
    send(8'h49, 8'd0, "R7 enable-all refused");

    repeat (3) @(negedge clk);
    check("R10 no pending completions", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule